// File: doc/BRIEF.md
# Packet SRAM Partition and Receive Threshold Controller

This block divides a byte-addressed packet SRAM into a transmit region and a receive region. The split point is a programmable page number, and one page is 512 bytes. The block holds three configuration registers: the split page, the SRAM size in pages, and a control byte. From these it derives the base and limit byte addresses of each region. It also keeps wrapping write and read pointers, with full and empty flags, for the transmit queue and the receive queue.

The block also decides when to request a receive DMA transfer for the frame now arriving. In normal mode the request is raised when the buffered byte count reaches a selectable watermark, or when the frame ends. In low-latency mode several things change. Receive data bypasses the SRAM, the whole SRAM serves transmit, the split page is ignored, and the request threshold is fixed at 16 bytes. Configuration writes are accepted only while the stop input is high. A configuration-error output flags a split that leaves either queue too small.

Top module: `sram_split_ctrl`

## Requirements
- R1: The split-page register (cfg_sel_i=0) reads back on cfg_rdata_o at all times. It is written only when stop_i is high. Hard reset (rst_ni low) clears it to 0, and soft_rst_i leaves it unchanged. The size register (cfg_sel_i=1, in pages) follows the same rules.
- R2: The control register (cfg_sel_i=2) holds the low-latency enable in bit 0 and the watermark select in bits 2:1. It is written only when stop_i is high. Hard reset clears both fields. soft_rst_i clears bit 0 and leaves bits 2:1 unchanged.
- R3: In normal mode with size S>0 and split page B, the transmit region is 0 to B*512-1 and the receive region is B*512 to S*512-1. With S=0, all six base and limit outputs read 0.
- R4: Low-latency mode (lolat_o=1) is active only when bit 0 is set and S is non-zero. In that mode the transmit region is 0 to S*512-1, B has no effect, the receive base and limit read 0, and the receive queue ignores push.
- R5: cfg_err_o is high when S>0, low-latency mode is off, and any of these holds: B<4, B>13h, or B+4>S. Otherwise it is low.
- R6: Each queue pointer moves up by one byte per accepted push or pop. It wraps from the region limit back to the region base.
- R7: A queue is empty when its pointers and wrap bits are equal. It is full when the pointers are equal and the wrap bits differ. A push while full and a pop while empty are ignored.
- R8: In normal mode the watermark select picks the receive threshold: 0 gives 16 bytes, 1 gives 64, and 2 or 3 gives 112. rx_dma_req_o rises in the cycle after the frame byte count reaches the threshold.
- R9: rx_eof_i raises rx_dma_req_o in the following cycle, whatever the byte count.
- R10: In low-latency mode the threshold is 16 bytes, whatever the watermark select says.
- R11: dma_ack_i clears the byte count and the pending end-of-frame flag, so rx_dma_req_o drops. A byte that arrives in the same cycle as the acknowledge counts as the first byte of the new count.
- R12: While stop_i is high, both queues return to their region base and read empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hard reset |
| soft_rst_i | input | 1 | Synchronous soft reset |
| stop_i | input | 1 | Stop control; enables configuration writes and holds the queues at their base |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Register select: 0 split page, 1 size, 2 control |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rdata_o | output | 8 | Read data of the selected register |
| lolat_o | output | 1 | Low-latency mode is in effect |
| cfg_err_o | output | 1 | Invalid partition |
| tx_base_o | output | 17 | Transmit region base byte address |
| tx_limit_o | output | 17 | Transmit region last byte address |
| rx_base_o | output | 17 | Receive region base byte address |
| rx_limit_o | output | 17 | Receive region last byte address |
| tx_push_i | input | 1 | Transmit byte written |
| tx_pop_i | input | 1 | Transmit byte read |
| tx_wptr_o | output | 17 | Transmit write pointer |
| tx_rptr_o | output | 17 | Transmit read pointer |
| tx_full_o | output | 1 | Transmit queue full |
| tx_empty_o | output | 1 | Transmit queue empty |
| rx_push_i | input | 1 | Receive byte written |
| rx_pop_i | input | 1 | Receive byte read |
| rx_wptr_o | output | 17 | Receive write pointer |
| rx_rptr_o | output | 17 | Receive read pointer |
| rx_full_o | output | 1 | Receive queue full |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_byte_i | input | 1 | One byte of the current frame arrived |
| rx_eof_i | input | 1 | Current frame ended |
| dma_ack_i | input | 1 | DMA engine took the pending data |
| rx_dma_req_o | output | 1 | Receive DMA request |

## Verification
Two events can land in the same cycle: the acknowledge that clears the receive byte count, and the arrival of a new byte. The bench provokes this by raising dma_ack_i and rx_byte_i together once a request is pending. It then judges the outcome by counting how many further bytes are needed before the 16-byte request reappears. Fifteen more bytes are expected, not sixteen. Low-latency override and end-of-frame are also set against the watermark, to show which source raises the request first.

// File: rtl/sram_split_pkg.sv
package sram_split_pkg;
  localparam int unsigned PAGE_BITS = 9;
  localparam int unsigned CNT_W     = 8;
  localparam logic [CNT_W-1:0] THR_LL = 8'd16;
  localparam logic [CNT_W-1:0] THR_0  = 8'd16;
  localparam logic [CNT_W-1:0] THR_1  = 8'd64;
  localparam logic [CNT_W-1:0] THR_2  = 8'd112;

  typedef enum logic [1:0] {SEL_BND = 2'd0, SEL_SIZE = 2'd1, SEL_CTRL = 2'd2} cfg_sel_e;

  function automatic logic [CNT_W-1:0] rx_thresh(input logic [1:0] sel, input logic ll);
    if (ll) return THR_LL;
    case (sel)
      2'd0:    return THR_0;
      2'd1:    return THR_1;
      default: return THR_2;
    endcase
  endfunction
endpackage

// File: rtl/sram_split_regs.sv
module sram_split_regs
  import sram_split_pkg::*;
#(
  parameter int unsigned BND_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             stop_i,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [BND_W-1:0] wdata_i,
  output logic [BND_W-1:0] rdata_o,
  output logic [BND_W-1:0] bnd_o,
  output logic [BND_W-1:0] size_o,
  output logic             ll_o,
  output logic [1:0]       wm_o
);
  logic wr_ok;
  assign wr_ok = we_i & stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bnd_o  <= '0;
      size_o <= '0;
      ll_o   <= 1'b0;
      wm_o   <= 2'd0;
    end else begin
      if (wr_ok && sel_i == SEL_BND)  bnd_o  <= wdata_i;
      if (wr_ok && sel_i == SEL_SIZE) size_o <= wdata_i;
      if (wr_ok && sel_i == SEL_CTRL) wm_o   <= wdata_i[2:1];
      // soft reset wins over a same-cycle write of the enable bit
      if (soft_rst_i)                      ll_o <= 1'b0;
      else if (wr_ok && sel_i == SEL_CTRL) ll_o <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel_i)
      SEL_BND:  rdata_o = bnd_o;
      SEL_SIZE: rdata_o = size_o;
      SEL_CTRL: rdata_o[2:0] = {wm_o, ll_o};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sram_split_map.sv
module sram_split_map
  import sram_split_pkg::*;
#(
  parameter int unsigned BND_W     = 8,
  parameter int unsigned MIN_PAGES = 4,
  parameter logic [7:0]  BND_MAX   = 8'h13,
  localparam int unsigned ADDR_W   = BND_W + PAGE_BITS
) (
  input  logic [BND_W-1:0]  bnd_i,
  input  logic [BND_W-1:0]  size_i,
  input  logic              ll_req_i,
  output logic              ll_o,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] tx_base_o,
  output logic [ADDR_W-1:0] tx_limit_o,
  output logic [ADDR_W-1:0] rx_base_o,
  output logic [ADDR_W-1:0] rx_limit_o
);
  logic              sram_en;
  logic [ADDR_W-1:0] bnd_addr, top_addr;
  logic              too_low, too_high, rx_short;

  assign sram_en  = |size_i;
  assign ll_o     = ll_req_i & sram_en;
  assign tx_en_o  = sram_en;
  assign rx_en_o  = sram_en & ~ll_o;
  assign bnd_addr = {bnd_i, {PAGE_BITS{1'b0}}};
  assign top_addr = {size_i, {PAGE_BITS{1'b0}}};

  assign too_low  = bnd_i < BND_W'(MIN_PAGES);
  assign too_high = bnd_i > BND_W'(BND_MAX);
  assign rx_short = ({1'b0, bnd_i} + (BND_W+1)'(MIN_PAGES)) > {1'b0, size_i};
  assign err_o    = rx_en_o & (too_low | too_high | rx_short);

  always_comb begin
    tx_base_o  = '0;
    tx_limit_o = '0;
    rx_base_o  = '0;
    rx_limit_o = '0;
    if (ll_o) begin
      tx_limit_o = top_addr - 1'b1;
    end else if (sram_en) begin
      tx_limit_o = bnd_addr - 1'b1;
      rx_base_o  = bnd_addr;
      rx_limit_o = top_addr - 1'b1;
    end
  end
endmodule

// File: rtl/sram_split_queue.sv
module sram_split_queue #(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              init_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] limit_i,
  input  logic              push_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] wptr_o,
  output logic [ADDR_W-1:0] rptr_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [ADDR_W-1:0] woff, roff, last_off;
  logic              wwrap, rwrap, do_push, do_pop, same;

  assign last_off = limit_i - base_i;
  assign same     = (woff == roff);
  assign empty_o  = same & (wwrap == rwrap);
  assign full_o   = same & (wwrap != rwrap);
  assign do_push  = en_i & push_i & ~full_o;
  assign do_pop   = en_i & pop_i & ~empty_o;
  assign wptr_o   = base_i + woff;
  assign rptr_o   = base_i + roff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      woff <= '0; roff <= '0; wwrap <= 1'b0; rwrap <= 1'b0;
    end else if (!en_i || init_i) begin
      woff <= '0; roff <= '0; wwrap <= 1'b0; rwrap <= 1'b0;
    end else begin
      if (do_push) begin
        if (woff == last_off) begin woff <= '0; wwrap <= ~wwrap; end
        else woff <= woff + 1'b1;
      end
      if (do_pop) begin
        if (roff == last_off) begin roff <= '0; rwrap <= ~rwrap; end
        else roff <= roff + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sram_split_rxthr.sv
module sram_split_rxthr
  import sram_split_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ll_i,
  input  logic [1:0] wm_i,
  input  logic       byte_i,
  input  logic       eof_i,
  input  logic       ack_i,
  output logic       req_o
);
  logic [CNT_W-1:0] cnt;
  logic             eof_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt      <= '0;
      eof_seen <= 1'b0;
    end else begin
      eof_seen <= (eof_seen & ~ack_i) | eof_i;
      if (ack_i)                      cnt <= CNT_W'(byte_i);
      else if (byte_i && cnt != '1)   cnt <= cnt + 1'b1;
    end
  end

  assign req_o = (cnt >= rx_thresh(wm_i, ll_i)) | eof_seen;
endmodule

// File: rtl/sram_split_ctrl.sv
module sram_split_ctrl
  import sram_split_pkg::*;
#(
  parameter int unsigned BND_W     = 8,
  parameter int unsigned MIN_PAGES = 4,
  parameter logic [7:0]  BND_MAX   = 8'h13,
  localparam int unsigned ADDR_W   = BND_W + PAGE_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              stop_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [BND_W-1:0]  cfg_wdata_i,
  output logic [BND_W-1:0]  cfg_rdata_o,
  output logic              lolat_o,
  output logic              cfg_err_o,
  output logic [ADDR_W-1:0] tx_base_o,
  output logic [ADDR_W-1:0] tx_limit_o,
  output logic [ADDR_W-1:0] rx_base_o,
  output logic [ADDR_W-1:0] rx_limit_o,
  input  logic              tx_push_i,
  input  logic              tx_pop_i,
  output logic [ADDR_W-1:0] tx_wptr_o,
  output logic [ADDR_W-1:0] tx_rptr_o,
  output logic              tx_full_o,
  output logic              tx_empty_o,
  input  logic              rx_push_i,
  input  logic              rx_pop_i,
  output logic [ADDR_W-1:0] rx_wptr_o,
  output logic [ADDR_W-1:0] rx_rptr_o,
  output logic              rx_full_o,
  output logic              rx_empty_o,
  input  logic              rx_byte_i,
  input  logic              rx_eof_i,
  input  logic              dma_ack_i,
  output logic              rx_dma_req_o
);
  logic [BND_W-1:0] bnd_q, size_q;
  logic             lolat_q, tx_en, rx_en;
  logic [1:0]       wm_q;

  sram_split_regs #(.BND_W(BND_W)) u_regs (
    .clk_i, .rst_ni, .soft_rst_i, .stop_i,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o),
    .bnd_o(bnd_q), .size_o(size_q), .ll_o(lolat_q), .wm_o(wm_q)
  );

  sram_split_map #(.BND_W(BND_W), .MIN_PAGES(MIN_PAGES), .BND_MAX(BND_MAX)) u_map (
    .bnd_i(bnd_q), .size_i(size_q), .ll_req_i(lolat_q),
    .ll_o(lolat_o), .tx_en_o(tx_en), .rx_en_o(rx_en), .err_o(cfg_err_o),
    .tx_base_o, .tx_limit_o, .rx_base_o, .rx_limit_o
  );

  // index 0: transmit queue, index 1: receive queue
  logic [1:0]             q_en, q_push, q_pop, q_full, q_empty;
  logic [1:0][ADDR_W-1:0] q_base, q_limit, q_wptr, q_rptr;

  assign q_en    = {rx_en, tx_en};
  assign q_push  = {rx_push_i, tx_push_i};
  assign q_pop   = {rx_pop_i, tx_pop_i};
  assign q_base  = {rx_base_o, tx_base_o};
  assign q_limit = {rx_limit_o, tx_limit_o};

  for (genvar g = 0; g < 2; g++) begin : g_q
    sram_split_queue #(.ADDR_W(ADDR_W)) u_q (
      .clk_i, .rst_ni, .en_i(q_en[g]), .init_i(stop_i),
      .base_i(q_base[g]), .limit_i(q_limit[g]),
      .push_i(q_push[g]), .pop_i(q_pop[g]),
      .wptr_o(q_wptr[g]), .rptr_o(q_rptr[g]),
      .full_o(q_full[g]), .empty_o(q_empty[g])
    );
  end

  assign tx_wptr_o  = q_wptr[0];
  assign tx_rptr_o  = q_rptr[0];
  assign tx_full_o  = q_full[0];
  assign tx_empty_o = q_empty[0];
  assign rx_wptr_o  = q_wptr[1];
  assign rx_rptr_o  = q_rptr[1];
  assign rx_full_o  = q_full[1];
  assign rx_empty_o = q_empty[1];

  sram_split_rxthr u_rxthr (
    .clk_i, .rst_ni, .ll_i(lolat_o), .wm_i(wm_q),
    .byte_i(rx_byte_i), .eof_i(rx_eof_i), .ack_i(dma_ack_i), .req_o(rx_dma_req_o)
  );
endmodule

// File: rtl/sram_split_chk.sv
module sram_split_chk #(
  parameter int unsigned BND_W  = 8,
  parameter int unsigned ADDR_W = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic              stop_i,
  input logic [BND_W-1:0]  bnd_q,
  input logic [BND_W-1:0]  size_q,
  input logic              lolat_q,
  input logic              lolat_o,
  input logic              cfg_err_o,
  input logic [ADDR_W-1:0] rx_limit_o,
  input logic [ADDR_W-1:0] rx_wptr_o,
  input logic              tx_full_o,
  input logic              tx_empty_o,
  input logic              rx_full_o,
  input logic              rx_empty_o,
  input logic              rx_byte_i,
  input logic              rx_eof_i,
  input logic              dma_ack_i,
  input logic              rx_dma_req_o
);
  p_bnd_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_i |=> $stable(bnd_q));
  p_size_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_i |=> $stable(size_q));
  p_soft_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !lolat_q);
  p_ll_rx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lolat_o |-> (rx_limit_o == '0 && rx_empty_o && rx_wptr_o == '0));
  p_err_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_q == '0 || lolat_o) |-> !cfg_err_o);
  p_flags_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_full_o && tx_empty_o) && !(rx_full_o && rx_empty_o));
  p_stop_empty_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (tx_empty_o && rx_empty_o));
  p_ack_clr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_ack_i && !rx_byte_i && !rx_eof_i) |=> !rx_dma_req_o);
endmodule

bind sram_split_ctrl sram_split_chk #(.BND_W(BND_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i), .stop_i(stop_i),
  .bnd_q(bnd_q), .size_q(size_q), .lolat_q(lolat_q), .lolat_o(lolat_o),
  .cfg_err_o(cfg_err_o), .rx_limit_o(rx_limit_o), .rx_wptr_o(rx_wptr_o),
  .tx_full_o(tx_full_o), .tx_empty_o(tx_empty_o),
  .rx_full_o(rx_full_o), .rx_empty_o(rx_empty_o),
  .rx_byte_i(rx_byte_i), .rx_eof_i(rx_eof_i), .dma_ack_i(dma_ack_i),
  .rx_dma_req_o(rx_dma_req_o)
);

// File: tb/sram_split_ctrl_tb.sv
`timescale 1ns/1ps
module sram_split_ctrl_tb;
  logic        clk_i = 1'b0, rst_ni = 1'b0, soft_rst_i = 1'b0, stop_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_sel_i = 2'd0;
  logic [7:0]  cfg_wdata_i = 8'd0, cfg_rdata_o;
  logic        lolat_o, cfg_err_o;
  logic [16:0] tx_base_o, tx_limit_o, rx_base_o, rx_limit_o;
  logic        tx_push_i = 0, tx_pop_i = 0, rx_push_i = 0, rx_pop_i = 0;
  logic [16:0] tx_wptr_o, tx_rptr_o, rx_wptr_o, rx_rptr_o;
  logic        tx_full_o, tx_empty_o, rx_full_o, rx_empty_o;
  logic        rx_byte_i = 0, rx_eof_i = 0, dma_ack_i = 0, rx_dma_req_o;

  int n_chk = 0, n_err = 0;

  always #5 clk_i = ~clk_i;

  sram_split_ctrl u_dut (.*);

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    tick();
    cfg_we_i = 1'b0;
  endtask

  task automatic cfg(input logic [7:0] b, input logic [7:0] s, input logic [7:0] c);
    stop_i = 1'b1;
    wr(2'd0, b); wr(2'd1, s); wr(2'd2, c);
    stop_i = 1'b0;
    tick();
  endtask

  task automatic bytes(input int n);
    rx_byte_i = 1'b1;
    for (int i = 0; i < n; i++) tick();
    rx_byte_i = 1'b0;
  endtask

  task automatic ack();
    dma_ack_i = 1'b1; tick(); dma_ack_i = 1'b0;
  endtask

  // {bnd, size, ll, tx_limit, rx_base, rx_limit, err}
  localparam int NV = 10;
  localparam logic [68:0] VEC [NV] = '{
    {8'h04, 8'h08, 1'b0, 17'h007FF, 17'h00800, 17'h00FFF, 1'b0},
    {8'h13, 8'h20, 1'b0, 17'h025FF, 17'h02600, 17'h03FFF, 1'b0},
    {8'h03, 8'h08, 1'b0, 17'h005FF, 17'h00600, 17'h00FFF, 1'b1},
    {8'h14, 8'h40, 1'b0, 17'h027FF, 17'h02800, 17'h07FFF, 1'b1},
    {8'h06, 8'h06, 1'b0, 17'h00BFF, 17'h00C00, 17'h00BFF, 1'b1},
    {8'h05, 8'h08, 1'b0, 17'h009FF, 17'h00A00, 17'h00FFF, 1'b1},
    {8'h05, 8'h00, 1'b0, 17'h00000, 17'h00000, 17'h00000, 1'b0},
    {8'h05, 8'h08, 1'b1, 17'h00FFF, 17'h00000, 17'h00000, 1'b0},
    {8'h03, 8'h00, 1'b1, 17'h00000, 17'h00000, 17'h00000, 1'b0},
    {8'h00, 8'h10, 1'b1, 17'h01FFF, 17'h00000, 17'h00000, 1'b0}
  };

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #22 rst_ni = 1'b1;
    tick();
    // reset state
    cfg_sel_i = 2'd0; #1 chk("R1 reset bnd", cfg_rdata_o, 0);
    cfg_sel_i = 2'd1; #1 chk("R1 reset size", cfg_rdata_o, 0);
    cfg_sel_i = 2'd2; #1 chk("R2 reset ctrl", cfg_rdata_o, 0);
    chk("R8 reset req", rx_dma_req_o, 0);
    chk("R5 reset err", cfg_err_o, 0);
    chk("R7 reset empty", tx_empty_o, 1);

    // partition table
    for (int i = 0; i < NV; i++) begin
      logic [68:0] v;
      v = VEC[i];
      cfg(v[68:61], v[60:53], {7'd0, v[52]});
      chk($sformatf("R3 tx_base v%0d", i), tx_base_o, 0);
      chk($sformatf("R3 tx_limit v%0d", i), tx_limit_o, v[51:35]);
      chk($sformatf("R3 rx_base v%0d", i), rx_base_o, v[34:18]);
      chk($sformatf("R3 rx_limit v%0d", i), rx_limit_o, v[17:1]);
      chk($sformatf("R5 err v%0d", i), cfg_err_o, v[0]);
      chk($sformatf("R4 lolat v%0d", i), lolat_o, v[52] & (v[60:53] != 0));
    end

    // R1/R2 write protection and soft reset
    cfg(8'h04, 8'h08, 8'h05);
    wr(2'd0, 8'h09);
    cfg_sel_i = 2'd0; #1 chk("R1 bnd write while running ignored", cfg_rdata_o, 8'h04);
    wr(2'd2, 8'h00);
    cfg_sel_i = 2'd2; #1 chk("R2 ctrl write while running ignored", cfg_rdata_o, 8'h05);
    soft_rst_i = 1'b1; tick(); soft_rst_i = 1'b0;
    cfg_sel_i = 2'd0; #1 chk("R1 bnd kept by soft reset", cfg_rdata_o, 8'h04);
    cfg_sel_i = 2'd1; #1 chk("R1 size kept by soft reset", cfg_rdata_o, 8'h08);
    cfg_sel_i = 2'd2; #1 chk("R2 soft reset clears ll keeps wm", cfg_rdata_o, 8'h04);

    // queues: bnd 4, size 8, normal
    cfg(8'h04, 8'h08, 8'h00);
    tx_push_i = 1; tick(); tick(); tick(); tx_push_i = 0;
    chk("R6 tx wptr after 3", tx_wptr_o, 3);
    chk("R7 tx not empty", tx_empty_o, 0);
    stop_i = 1; tick(); stop_i = 0;
    chk("R12 stop resets tx wptr", tx_wptr_o, 0);
    chk("R12 stop empties tx", tx_empty_o, 1);
    rx_push_i = 1;
    for (int i = 0; i < 2048; i++) tick();
    rx_push_i = 0;
    chk("R7 rx full", rx_full_o, 1);
    chk("R6 rx wptr wrapped to base", rx_wptr_o, 17'h800);
    rx_push_i = 1; tick(); rx_push_i = 0;
    chk("R7 push on full ignored", rx_wptr_o, 17'h800);
    chk("R7 still full", rx_full_o, 1);
    rx_pop_i = 1; tick(); rx_pop_i = 0;
    chk("R6 rx rptr step", rx_rptr_o, 17'h801);
    chk("R7 not full after pop", rx_full_o, 0);
    rx_pop_i = 1;
    for (int i = 0; i < 2047; i++) tick();
    rx_pop_i = 0;
    chk("R7 rx empty", rx_empty_o, 1);
    chk("R6 rx rptr wrapped", rx_rptr_o, 17'h800);
    rx_pop_i = 1; tick(); rx_pop_i = 0;
    chk("R7 pop on empty ignored", rx_rptr_o, 17'h800);

    // R4 receive queue ignored in low latency
    cfg(8'h04, 8'h08, 8'h01);
    rx_push_i = 1; tick(); tick(); rx_push_i = 0;
    chk("R4 rx push ignored empty", rx_empty_o, 1);
    chk("R4 rx push ignored wptr", rx_wptr_o, 0);

    // thresholds, normal mode
    cfg(8'h04, 8'h08, 8'h00); ack();
    bytes(15); chk("R8 sel0 15 bytes", rx_dma_req_o, 0);
    bytes(1);  chk("R8 sel0 16 bytes", rx_dma_req_o, 1);
    ack();     chk("R11 ack clears req", rx_dma_req_o, 0);
    cfg(8'h04, 8'h08, 8'h02); ack();
    bytes(63); chk("R8 sel1 63 bytes", rx_dma_req_o, 0);
    bytes(1);  chk("R8 sel1 64 bytes", rx_dma_req_o, 1);
    cfg(8'h04, 8'h08, 8'h04); ack();
    bytes(111); chk("R8 sel2 111 bytes", rx_dma_req_o, 0);
    bytes(1);   chk("R8 sel2 112 bytes", rx_dma_req_o, 1);
    cfg(8'h04, 8'h08, 8'h06); ack();
    bytes(111); chk("R8 sel3 111 bytes", rx_dma_req_o, 0);
    bytes(1);   chk("R8 sel3 112 bytes", rx_dma_req_o, 1);
    // R10 low latency overrides sel 2
    cfg(8'h04, 8'h08, 8'h05); ack();
    bytes(15); chk("R10 ll 15 bytes", rx_dma_req_o, 0);
    bytes(1);  chk("R10 ll 16 bytes", rx_dma_req_o, 1);
    // R4 ll ineffective with size 0 -> sel 2 applies
    cfg(8'h04, 8'h00, 8'h05); ack();
    bytes(16); chk("R4 ll needs size, 16 bytes", rx_dma_req_o, 0);
    // R9 end of frame
    cfg(8'h04, 8'h08, 8'h04); ack();
    bytes(3);
    rx_eof_i = 1; tick(); rx_eof_i = 0;
    chk("R9 eof raises req", rx_dma_req_o, 1);
    ack(); chk("R11 ack clears eof", rx_dma_req_o, 0);
    // R11 ack and byte together
    cfg(8'h04, 8'h08, 8'h00); ack();
    bytes(16); chk("R8 req before combined ack", rx_dma_req_o, 1);
    dma_ack_i = 1; rx_byte_i = 1; tick(); dma_ack_i = 0; rx_byte_i = 0;
    chk("R11 req drops on combined ack", rx_dma_req_o, 0);
    bytes(14); chk("R11 1+14 bytes", rx_dma_req_o, 0);
    bytes(1);  chk("R11 1+15 bytes", rx_dma_req_o, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule